// File: doc/BRIEF.md
# Final Fragment Combiner

This block is the closing per-pixel arithmetic stage of a fragment pipeline. Each pixel arrives with a register set already filled in by earlier stages: primary color, secondary color, two texture results, two spare registers and a fog value. Two constant colors come from static configuration. From this set the block selects four operands A, B, C and D. It produces the RGB result as A·B + (1−A)·C + D. The alpha result is one selected operand G.

Two derived sources widen the choice for A to D and G. The first is the product of two further selected operands, E and F. The second is the saturated sum of spare 0 and secondary color. Every operand can be inverted on its way in, and all arithmetic runs on unsigned fractions in the range [0, 1].

Pixels stream in and out through valid/ready handshakes. One pixel can be accepted on every clock. The pipeline has two register stages: products first, then sums.

Top module: `fc_final_combiner`

## Requirements
- R1: The select codes are 0 zero, 1 primary, 2 secondary, 3 texture 0, 4 texture 1, 5 spare 0, 6 spare 1, 7 fog, 8 constant 0, 9 constant 1, 10 E·F product and 11 spare-0-plus-secondary sum. Codes 12 to 15 read as zero. Selection is applied separately to each component.
- R2: Each RGB component is r = min((A·B + (256−A)·C + 256·D + 128) >> 8, 256), where 256 stands for 1.0 (FRAC = 8). A, B, C and D are the mapped operands for that component.
- R3: Alpha is the mapped operand G, taken from the alpha components of the sources. The choices for A through D have no effect on alpha.
- R4: The E·F source is (E·F + 128) >> 8 for each component, using the mapped E and F. When E or F selects code 10 or higher, that operand reads as zero before mapping.
- R5: The sum source is min(spare0 + secondary, 256) for each component, computed after clamping.
- R6: Bits 0 to 6 of cfg_invert belong to A, B, C, D, E, F and G, in that order. A set bit replaces the operand value x with 256 − x.
- R7: Register and constant inputs are signed two's-complement, IN_W bits wide. Each one is clamped to [0, 256] before selection.
- R8: Each output byte is (r·255 + 128) >> 8. Red sits in out_rgba[7:0], green in [15:8], blue in [23:16] and alpha in [31:24]. Input component k occupies bits [k·IN_W +: IN_W] in the same R, G, B, A order.
- R9: A pixel accepted at a rising edge appears with out_valid on the second rising edge after it, provided the output is not stalled. Back-to-back pixels come out on consecutive cycles.
- R10: While out_valid is high and out_ready is low, out_valid and out_rgba hold steady and in_ready is low. Otherwise in_ready is high.
- R11: During reset out_valid is 0 and out_rgba is 0. After reset in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| reg_pri | input | 4·IN_W | Primary color, RGBA |
| reg_sec | input | 4·IN_W | Secondary color, RGBA |
| reg_tex0 | input | 4·IN_W | Texture 0 result, RGBA |
| reg_tex1 | input | 4·IN_W | Texture 1 result, RGBA |
| reg_spare0 | input | 4·IN_W | Spare register 0, RGBA |
| reg_spare1 | input | 4·IN_W | Spare register 1, RGBA |
| reg_fog | input | 4·IN_W | Fog color and factor, RGBA |
| cfg_const0 | input | 4·IN_W | Constant color 0 |
| cfg_const1 | input | 4·IN_W | Constant color 1 |
| sel_a | input | 4 | Source code for A |
| sel_b | input | 4 | Source code for B |
| sel_c | input | 4 | Source code for C |
| sel_d | input | 4 | Source code for D |
| sel_e | input | 4 | Source code for E |
| sel_f | input | 4 | Source code for F |
| sel_g | input | 4 | Source code for G (alpha) |
| cfg_invert | input | 7 | Invert flags for A to G |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_rgba | output | 4·OUT_W | Final color, RGBA |

## Verification
The assertions check the handshake behaviour on every cycle. They confirm that a stalled output stays frozen, that a pixel accepted on an unstalled path emerges two edges later, and that the E·F product and the mapped E and F operands never leave the unit range. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the interpolate-plus-add result with its saturation, the derived sources, inversion, clamping of negative and oversized inputs, the zero codes, and the isolation of alpha from the RGB operand choices.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int SEL_W = 4;
  localparam int NSRC  = 1 << SEL_W;
  localparam int NREG  = 9;   // stored register-set entries, codes 1..NREG
  localparam int NOPS  = 7;   // operands A..G

  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO   = 4'd0,
    SRC_PRI    = 4'd1,
    SRC_SEC    = 4'd2,
    SRC_TEX0   = 4'd3,
    SRC_TEX1   = 4'd4,
    SRC_SPARE0 = 4'd5,
    SRC_SPARE1 = 4'd6,
    SRC_FOG    = 4'd7,
    SRC_CONST0 = 4'd8,
    SRC_CONST1 = 4'd9,
    SRC_EF     = 4'd10,
    SRC_SUM    = 4'd11
  } src_e;
endpackage

// File: rtl/fc_src_mux.sv
module fc_src_mux
  import fc_pkg::*;
#(
  parameter int FRAC = 8,
  parameter int UW   = FRAC + 1
) (
  input  logic [NSRC-1:0][UW-1:0] srcs,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    inv,
  output logic [UW-1:0]           val
);
  localparam logic [UW-1:0] ONE = UW'(1 << FRAC);

  logic [UW-1:0] raw;

  always_comb begin
    raw = srcs[sel];
    val = inv ? (ONE - raw) : raw;
  end
endmodule

// File: rtl/fc_lane.sv
module fc_lane
  import fc_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int FRAC  = 8,
  parameter int OUT_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [NREG-1:0][IN_W-1:0]   regs,
  input  logic [5:0][SEL_W-1:0]       sel,
  input  logic [5:0]                  inv,
  output logic [OUT_W-1:0]            pix
);
  localparam int UW    = FRAC + 1;
  localparam int ONE_I = 1 << FRAC;
  localparam int ACC_W = 2 * UW + 2;
  localparam logic [UW-1:0]    ONE   = UW'(ONE_I);
  localparam logic [ACC_W-1:0] ONE_A = ACC_W'(ONE_I);
  localparam logic [ACC_W-1:0] HALF  = ACC_W'(1 << (FRAC - 1));
  localparam logic [ACC_W-1:0] MAXO  = ACC_W'((1 << OUT_W) - 1);

  function automatic logic [UW-1:0] clampv(input logic signed [IN_W-1:0] x);
    if (x < 0) return '0;
    if (int'(x) > ONE_I) return ONE;
    return x[UW-1:0];
  endfunction

  logic [NSRC-1:0][UW-1:0] base_srcs;
  logic [NSRC-1:0][UW-1:0] full_srcs;
  logic [UW-1:0]           e_v, f_v, ef_v, sum_v;
  logic [UW:0]             sum_raw;
  logic [ACC_W-1:0]        ef_full;
  logic [3:0][UW-1:0]      mix_v;

  // Register-set sources, clamped; derived and spare codes read zero here
  always_comb begin
    base_srcs = '0;
    for (int k = 0; k < NREG; k++) base_srcs[k+1] = clampv(regs[k]);
  end

  fc_src_mux #(.FRAC(FRAC), .UW(UW)) u_mux_e (
    .srcs(base_srcs), .sel(sel[4]), .inv(inv[4]), .val(e_v));
  fc_src_mux #(.FRAC(FRAC), .UW(UW)) u_mux_f (
    .srcs(base_srcs), .sel(sel[5]), .inv(inv[5]), .val(f_v));

  always_comb begin
    ef_full = ACC_W'(e_v) * ACC_W'(f_v) + HALF;
    ef_v    = UW'(ef_full >> FRAC);
    sum_raw = {1'b0, base_srcs[SRC_SPARE0]} + {1'b0, base_srcs[SRC_SEC]};
    sum_v   = (sum_raw > {1'b0, ONE}) ? ONE : sum_raw[UW-1:0];
    full_srcs          = base_srcs;
    full_srcs[SRC_EF]  = ef_v;
    full_srcs[SRC_SUM] = sum_v;
  end

  for (genvar i = 0; i < 4; i++) begin : g_op
    fc_src_mux #(.FRAC(FRAC), .UW(UW)) u_mux (
      .srcs(full_srcs), .sel(sel[i]), .inv(inv[i]), .val(mix_v[i]));
  end

  // Stage 1: products
  logic [ACC_W-1:0] ab_q, c_q;
  logic [UW-1:0]    d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q <= '0;
      c_q  <= '0;
      d_q  <= '0;
    end else if (en) begin
      ab_q <= ACC_W'(mix_v[0]) * ACC_W'(mix_v[1]);
      c_q  <= (ONE_A - ACC_W'(mix_v[0])) * ACC_W'(mix_v[2]);
      d_q  <= mix_v[3];
    end
  end

  // Stage 2: sum, saturate, convert to output width
  logic [ACC_W-1:0] acc, lin, lin_sat;
  logic [OUT_W-1:0] px_next;

  always_comb begin
    acc     = ab_q + c_q + (ACC_W'(d_q) << FRAC) + HALF;
    lin     = acc >> FRAC;
    lin_sat = (lin > ONE_A) ? ONE_A : lin;
    px_next = OUT_W'((lin_sat * MAXO + HALF) >> FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst)     pix <= '0;
    else if (en) pix <= px_next;
  end

  // R10: a stalled lane keeps its result
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pix));
  // R4: product of two unit-range operands stays in range
  p_ef_range_r4: assert property (@(posedge clk) disable iff (rst)
    ef_v <= ONE);
  // R7: clamped and mapped E/F operands stay in [0, 1]
  p_mapped_range_r7: assert property (@(posedge clk) disable iff (rst)
    (e_v <= ONE) && (f_v <= ONE));
endmodule

// File: rtl/fc_final_combiner.sv
module fc_final_combiner
  import fc_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int FRAC  = 8,
  parameter int OUT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [4*IN_W-1:0]     reg_pri,
  input  logic [4*IN_W-1:0]     reg_sec,
  input  logic [4*IN_W-1:0]     reg_tex0,
  input  logic [4*IN_W-1:0]     reg_tex1,
  input  logic [4*IN_W-1:0]     reg_spare0,
  input  logic [4*IN_W-1:0]     reg_spare1,
  input  logic [4*IN_W-1:0]     reg_fog,
  input  logic [4*IN_W-1:0]     cfg_const0,
  input  logic [4*IN_W-1:0]     cfg_const1,
  input  logic [SEL_W-1:0]      sel_a,
  input  logic [SEL_W-1:0]      sel_b,
  input  logic [SEL_W-1:0]      sel_c,
  input  logic [SEL_W-1:0]      sel_d,
  input  logic [SEL_W-1:0]      sel_e,
  input  logic [SEL_W-1:0]      sel_f,
  input  logic [SEL_W-1:0]      sel_g,
  input  logic [NOPS-1:0]       cfg_invert,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [4*OUT_W-1:0]    out_rgba
);
  localparam int NLANE = 4;
  localparam int ALPHA = NLANE - 1;

  logic en;
  logic v1_q;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
    end
  end

  for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
    logic [NREG-1:0][IN_W-1:0] lane_regs;
    logic [5:0][SEL_W-1:0]     lane_sel;
    logic [5:0]                lane_inv;

    assign lane_regs = {cfg_const1[ln*IN_W +: IN_W], cfg_const0[ln*IN_W +: IN_W],
                        reg_fog[ln*IN_W +: IN_W],    reg_spare1[ln*IN_W +: IN_W],
                        reg_spare0[ln*IN_W +: IN_W], reg_tex1[ln*IN_W +: IN_W],
                        reg_tex0[ln*IN_W +: IN_W],   reg_sec[ln*IN_W +: IN_W],
                        reg_pri[ln*IN_W +: IN_W]};

    if (ln == ALPHA) begin : g_alpha
      // Alpha reuses the lerp datapath as (1-0)*G: A=B=D=zero, C=G
      assign lane_sel = {sel_f, sel_e, SRC_ZERO, sel_g, SRC_ZERO, SRC_ZERO};
      assign lane_inv = {cfg_invert[5], cfg_invert[4], 1'b0, cfg_invert[6], 2'b00};
    end else begin : g_color
      assign lane_sel = {sel_f, sel_e, sel_d, sel_c, sel_b, sel_a};
      assign lane_inv = cfg_invert[5:0];
    end

    fc_lane #(.IN_W(IN_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .regs (lane_regs),
      .sel  (lane_sel),
      .inv  (lane_inv),
      .pix  (out_rgba[ln*OUT_W +: OUT_W])
    );
  end

  // R10: stalled output stays valid and unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgba)));
  // R9: accepted pixel with a free following cycle emerges two edges later
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);
endmodule

// File: tb/fc_final_combiner_test.sv
module fc_final_combiner_test;
  localparam int IN_W = 10;
  localparam int NV   = 10;

  typedef struct packed {
    logic [3:0] sa, sb, sc, sd, se, sf, sg;
    logic [6:0] inv;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd3, 4'd1, 4'd4, 4'd0, 4'd0, 4'd0, 4'd1,  7'h00},
    '{4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 4'd7,  7'h00},
    '{4'd8, 4'd10,4'd0, 4'd0, 4'd3, 4'd4, 4'd10, 7'h00},
    '{4'd8, 4'd11,4'd0, 4'd0, 4'd0, 4'd0, 4'd11, 7'h00},
    '{4'd2, 4'd1, 4'd1, 4'd2, 4'd0, 4'd0, 4'd2,  7'h00},
    '{4'd3, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd3,  7'h7f},
    '{4'd8, 4'd10,4'd0, 4'd0, 4'd10,4'd1, 4'd12, 7'h00},
    '{4'd0, 4'd0, 4'd0, 4'd13,4'd0, 4'd0, 4'd15, 7'h40},
    '{4'd0, 4'd0, 4'd9, 4'd0, 4'd0, 4'd0, 4'd9,  7'h00},
    '{4'd6, 4'd7, 4'd8, 4'd0, 4'd0, 4'd0, 4'd3,  7'h04}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2 lerp";
      1: return "R8 passthrough";
      2: return "R4 product";
      3: return "R5 sum";
      4: return "R2 saturate";
      5: return "R6 invert";
      6: return "R4 derived-in-EF";
      7: return "R1 zero codes";
      8: return "R7 clamp";
      default: return "R3 alpha isolation";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [4*IN_W-1:0] r_pri, r_sec, r_t0, r_t1, r_s0, r_s1, r_fog, c0, c1;
  logic [3:0] sa = '0, sb = '0, sc = '0, sd = '0, se = '0, sf = '0, sg = '0;
  logic [6:0] inv = '0;
  logic [31:0] out_rgba;

  int n_chk = 0, n_fail = 0;
  int rv [9][4];

  always #5 clk = ~clk;

  fc_final_combiner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .reg_pri(r_pri), .reg_sec(r_sec), .reg_tex0(r_t0), .reg_tex1(r_t1),
    .reg_spare0(r_s0), .reg_spare1(r_s1), .reg_fog(r_fog),
    .cfg_const0(c0), .cfg_const1(c1),
    .sel_a(sa), .sel_b(sb), .sel_c(sc), .sel_d(sd), .sel_e(se), .sel_f(sf),
    .sel_g(sg), .cfg_invert(inv), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgba(out_rgba)
  );

  function automatic int clampv(int x);
    if (x < 0) return 0;
    if (x > 256) return 256;
    return x;
  endfunction

  function automatic int mapv(int v, logic i);
    return i ? 256 - v : v;
  endfunction

  function automatic int basev(int code, int ln);
    if (code >= 1 && code <= 9) return clampv(rv[code-1][ln]);
    return 0;
  endfunction

  function automatic int srcv(int code, int ln, vec_t v);
    int e, f, s;
    if (code == 10) begin
      e = mapv(basev(int'(v.se), ln), v.inv[4]);
      f = mapv(basev(int'(v.sf), ln), v.inv[5]);
      return (e * f + 128) >> 8;
    end
    if (code == 11) begin
      s = basev(5, ln) + basev(2, ln);
      return (s > 256) ? 256 : s;
    end
    return basev(code, ln);
  endfunction

  function automatic logic [31:0] expect_px(vec_t v);
    logic [31:0] res;
    int a, b, c, d, r, o;
    res = '0;
    for (int ln = 0; ln < 4; ln++) begin
      if (ln == 3) begin
        r = mapv(srcv(int'(v.sg), ln, v), v.inv[6]);
      end else begin
        a = mapv(srcv(int'(v.sa), ln, v), v.inv[0]);
        b = mapv(srcv(int'(v.sb), ln, v), v.inv[1]);
        c = mapv(srcv(int'(v.sc), ln, v), v.inv[2]);
        d = mapv(srcv(int'(v.sd), ln, v), v.inv[3]);
        r = (a * b + (256 - a) * c + d * 256 + 128) >> 8;
        if (r > 256) r = 256;
      end
      o = (r * 255 + 128) >> 8;
      res[ln*8 +: 8] = o[7:0];
    end
    return res;
  endfunction

  task automatic check32(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(vec_t v);
    sa = v.sa; sb = v.sb; sc = v.sc; sd = v.sd;
    se = v.se; sf = v.sf; sg = v.sg; inv = v.inv;
  endtask

  task automatic load_regs();
    for (int l = 0; l < 4; l++) begin
      r_pri[l*IN_W +: IN_W] = rv[0][l][IN_W-1:0];
      r_sec[l*IN_W +: IN_W] = rv[1][l][IN_W-1:0];
      r_t0 [l*IN_W +: IN_W] = rv[2][l][IN_W-1:0];
      r_t1 [l*IN_W +: IN_W] = rv[3][l][IN_W-1:0];
      r_s0 [l*IN_W +: IN_W] = rv[4][l][IN_W-1:0];
      r_s1 [l*IN_W +: IN_W] = rv[5][l][IN_W-1:0];
      r_fog[l*IN_W +: IN_W] = rv[6][l][IN_W-1:0];
      c0   [l*IN_W +: IN_W] = rv[7][l][IN_W-1:0];
      c1   [l*IN_W +: IN_W] = rv[8][l][IN_W-1:0];
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rv = '{'{200, 100, 50, 255}, '{64, 128, 300, 10}, '{128, -20, 256, 128},
           '{32, 64, 96, 200},   '{220, 20, 0, 250},  '{1, 2, 3, 4},
           '{16, 240, 128, 77},  '{256, 256, 256, 256}, '{0, 128, 511, 64}};
    load_regs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check32("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check32("R11 out_rgba in reset", out_rgba, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check32("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // Table walk: one pixel at a time
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check32({tag_of(i), " valid"}, {31'd0, out_valid}, 32'd1);
      check32(tag_of(i), out_rgba, expect_px(VEC[i]));
    end

    // R9: back-to-back stream, one result per cycle
    repeat (2) @(posedge clk);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check32("R9 stream valid", {31'd0, out_valid}, 32'd1);
        check32("R9 stream data", out_rgba, expect_px(VEC[c-2]));
      end
      if (c < 4) begin
        drive(VEC[c]);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end

    // R10: backpressure
    repeat (3) @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[4]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(VEC[5]);
    @(posedge clk);
    @(negedge clk);
    drive(VEC[6]);
    check32("R10 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    check32("R10 first stalled data", out_rgba, expect_px(VEC[4]));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R10 held valid", {31'd0, out_valid}, 32'd1);
    check32("R10 held data", out_rgba, expect_px(VEC[4]));
    check32("R10 in_ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    in_valid  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check32("R10 drain second pixel", out_rgba, expect_px(VEC[5]));
    check32("R10 drain valid", {31'd0, out_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    check32("R10 empty after drain", {31'd0, out_valid}, 32'd0);

    finish_run();
  end
endmodule